// File: doc/BRIEF.md
# Serial Converter Command Receiver

This block is the digital front end of a serially programmed converter. A host drives four lines: an active-low select, a frame marker, a serial clock and a data line. The receiver assembles a 16-bit command from those lines and loads it into a held output register. That register presents an 8-bit code, a speed-select flag and a power-down flag to the downstream analog control logic.

All four serial lines are sampled by the much faster system clock through two-flop synchronizers. Edges are found in the system domain, and no logic is clocked by the serial clock. A word is committed on the first serial-clock rise after its sixteenth bit. It is also committed early when the frame marker goes high before the word is complete.

The loaded register is held, not streamed, so there is no valid/ready handshake and no back-pressure. Each load is announced by a single-cycle `upd_o` pulse, and downstream logic that has to see every load must sample on that pulse. With `cs_n_i` tied low the block works as a three-wire receiver.

Top module: `sdac_cmd_rx`

## Requirements
- R1: After reset, `code_o` is 0, `fast_o`, `pdown_o`, `bad_pad_o` and `upd_o` are 0.
- R2: While `cs_n_i` is high, activity on the frame, clock and data lines changes no output and produces no `upd_o` pulse.
- R3: A falling edge of `fs_i` while `cs_n_i` is low starts a new word and clears any partial one. Data is captured on falling edges of `sclk_i`, most significant bit first, up to 16 bits.
- R4: For a full 16-bit word, the output register loads on the first rising edge of `sclk_i` after the sixteenth capture. Bit 14 drives `fast_o` (1 = fast), bit 13 drives `pdown_o` (1 = powered down), bits 11..4 drive `code_o`, and bits 15 and 12 have no effect.
- R5: If `fs_i` rises after k captured bits, with 1 <= k <= 15, the word is committed at once. The k bits sit right-aligned in the 16-bit word and the upper bits are 0. If `fs_i` rises with no bit captured, nothing is loaded.
- R6: `bad_pad_o` is loaded with 1 when bits 3..0 of the committed word are not all zero, and with 0 otherwise. The word is loaded either way.
- R7: `upd_o` is high for exactly one clock cycle for each load of the output register. The outputs never change in a cycle without `upd_o`.
- R8: A rising edge of `cs_n_i` during a word aborts that word with no load. Clock edges that follow are ignored until the next frame start.
- R9: A serial edge that causes a load shows up on the outputs three system-clock edges after the edge appears at the pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n_i | input | 1 | Active-low select |
| fs_i | input | 1 | Frame marker; falling edge starts a word |
| sclk_i | input | 1 | Serial clock |
| sdata_i | input | 1 | Serial data, captured on serial clock falls |
| code_o | output | 8 | Loaded converter code |
| fast_o | output | 1 | Loaded speed-select flag |
| pdown_o | output | 1 | Loaded power-down flag |
| bad_pad_o | output | 1 | Last loaded word had nonzero padding bits |
| upd_o | output | 1 | One-cycle pulse on each load |

## Verification
The cases hardest to reach from the ports are the early commit and the abort, because each depends on when one line moves relative to a partly shifted word. The stimulus stops the serial clock after a chosen number of bits. It then raises either the frame marker or the select, and afterwards keeps clocking to show that the trailing edges are ignored. A behavioural model fed the same pin values, delayed by the synchronizer depth, is compared with every output on every clock. This pins down the three-edge latency as well as the loaded values.

// File: rtl/sdac_pkg.sv
package sdac_pkg;
  localparam int WORD_W   = 16;
  localparam int CODE_W   = 8;
  localparam int CODE_LSB = 4;
  localparam int PAD_W    = 4;
  localparam int FAST_BIT = 14;
  localparam int PDN_BIT  = 13;
  localparam int CNT_W    = $clog2(WORD_W + 1);

  typedef struct packed {
    logic [CODE_W-1:0] code;
    logic              fast;
    logic              pdown;
    logic              bad_pad;
  } dac_cfg_t;

  function automatic dac_cfg_t split_word(input logic [WORD_W-1:0] w);
    dac_cfg_t c;
    c.code    = w[CODE_LSB +: CODE_W];
    c.fast    = w[FAST_BIT];
    c.pdown   = w[PDN_BIT];
    c.bad_pad = |w[PAD_W-1:0];
    return c;
  endfunction
endpackage

// File: rtl/sdac_sync.sv
module sdac_sync #(
  parameter int             W       = 4,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[g] <= RST_VAL;
        else        chain[g] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[g] <= RST_VAL;
        else        chain[g] <= chain[g-1];
      end
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/sdac_edge.sv
module sdac_edge #(
  parameter int           W       = 3,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] level,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= RST_VAL;
    else        prev_q <= level;
  end

  assign rise = level & ~prev_q;
  assign fall = prev_q & ~level;
endmodule

// File: rtl/sdac_framer.sv
module sdac_framer
  import sdac_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              din,
  input  logic              cs_rise,
  input  logic              fs_rise,
  input  logic              fs_fall,
  input  logic              sck_rise,
  input  logic              sck_fall,
  output logic              commit,
  output logic [WORD_W-1:0] word
);
  logic              active_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [WORD_W-1:0] sh_q;
  logic              full;
  logic              early_ok;

  assign full     = (cnt_q == CNT_W'(WORD_W));
  assign early_ok = fs_rise && (cnt_q != '0);

  always_comb begin
    commit = 1'b0;
    if (!cs_n && active_q && !fs_fall) begin
      if (fs_rise)              commit = early_ok;
      else if (full && sck_rise) commit = 1'b1;
    end
  end

  assign word = sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      sh_q     <= '0;
    end else if (cs_rise && active_q) begin
      active_q <= 1'b0;
    end else if (!cs_n) begin
      if (fs_fall) begin
        active_q <= 1'b1;
        cnt_q    <= '0;
        sh_q     <= '0;
      end else if (active_q) begin
        if (fs_rise) begin
          active_q <= 1'b0;
        end else if (full && sck_rise) begin
          active_q <= 1'b0;
        end else if (!full && sck_fall) begin
          sh_q  <= {sh_q[WORD_W-2:0], din};
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(WORD_W));

  p_commit_in_frame_r4: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> active_q);

  p_abort_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise && active_q) |=> !active_q);

  p_cs_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && !cs_rise) |=> ($stable(active_q) && $stable(sh_q) && $stable(cnt_q)));
endmodule

// File: rtl/sdac_cmd_rx.sv
module sdac_cmd_rx
  import sdac_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n_i,
  input  logic              fs_i,
  input  logic              sclk_i,
  input  logic              sdata_i,
  output logic [CODE_W-1:0] code_o,
  output logic              fast_o,
  output logic              pdown_o,
  output logic              bad_pad_o,
  output logic              upd_o
);
  localparam int LINES = 4;
  localparam int EDGES = 3;

  logic [LINES-1:0]  raw_lines, sync_lines;
  logic [EDGES-1:0]  ev_rise, ev_fall;
  logic              s_din;
  logic              commit;
  logic [WORD_W-1:0] word;
  dac_cfg_t          cfg_q;
  logic              upd_q;

  assign raw_lines = {sdata_i, sclk_i, fs_i, cs_n_i};

  sdac_sync #(
    .W(LINES), .STAGES(SYNC_STAGES), .RST_VAL(4'b0111)
  ) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_lines), .q(sync_lines)
  );

  assign s_din = sync_lines[3];

  sdac_edge #(
    .W(EDGES), .RST_VAL(3'b111)
  ) u_edge (
    .clk(clk), .rst_n(rst_n), .level(sync_lines[2:0]),
    .rise(ev_rise), .fall(ev_fall)
  );

  sdac_framer u_framer (
    .clk(clk), .rst_n(rst_n),
    .cs_n(sync_lines[0]), .din(s_din),
    .cs_rise(ev_rise[0]),
    .fs_rise(ev_rise[1]), .fs_fall(ev_fall[1]),
    .sck_rise(ev_rise[2]), .sck_fall(ev_fall[2]),
    .commit(commit), .word(word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      upd_q <= 1'b0;
    end else begin
      upd_q <= commit;
      if (commit) cfg_q <= split_word(word);
    end
  end

  assign code_o    = cfg_q.code;
  assign fast_o    = cfg_q.fast;
  assign pdown_o   = cfg_q.pdown;
  assign bad_pad_o = cfg_q.bad_pad;
  assign upd_o     = upd_q;

  p_upd_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    upd_o |=> !upd_o);

  p_hold_without_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_o |-> ($stable(code_o) && $stable(fast_o) && $stable(pdown_o) && $stable(bad_pad_o)));
endmodule

// File: tb/sdac_cmd_rx_tb.sv
module sdac_cmd_rx_tb_top;
  localparam int H = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, fs = 1'b1, sclk = 1'b1, din = 1'b0;
  logic [7:0] code;
  logic fast, pdown, bad, upd;

  int n_checks = 0;
  int n_fail = 0;
  int upd_seen = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  sdac_cmd_rx dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n), .fs_i(fs), .sclk_i(sclk),
    .sdata_i(din), .code_o(code), .fast_o(fast), .pdown_o(pdown),
    .bad_pad_o(bad), .upd_o(upd)
  );

  // behavioural reference: pin history, edge events, word assembly
  logic [3:0] h1, h2, h3;            // {din, sclk, fs, cs_n}
  bit   m_active, m_full;
  int   m_cnt;
  logic [15:0] m_sh;
  logic [7:0] m_code;
  logic m_fast, m_pd, m_bad, m_upd;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h1 = 4'b0111; h2 = 4'b0111; h3 = 4'b0111;
      m_active = 0; m_full = 0; m_cnt = 0; m_sh = '0;
      m_code = '0; m_fast = 0; m_pd = 0; m_bad = 0; m_upd = 0;
    end else begin
      bit cs_up, fs_dn, fs_up, ck_dn, ck_up, do_load;
      cs_up = !h3[0] && h2[0];
      fs_dn = h3[1] && !h2[1];
      fs_up = !h3[1] && h2[1];
      ck_dn = h3[2] && !h2[2];
      ck_up = !h3[2] && h2[2];
      do_load = 0;
      if (cs_up && m_active) m_active = 0;
      else if (!h2[0]) begin
        if (fs_dn) begin
          m_active = 1; m_cnt = 0; m_sh = '0; m_full = 0;
        end else if (m_active) begin
          if (fs_up) begin
            do_load = (m_cnt > 0); m_active = 0;
          end else if (m_full && ck_up) begin
            do_load = 1; m_active = 0;
          end else if (!m_full && ck_dn) begin
            m_sh = {m_sh[14:0], h2[3]};
            m_cnt++;
            m_full = (m_cnt == 16);
          end
        end
      end
      m_upd = do_load;
      if (do_load) begin
        m_code = m_sh[11:4]; m_fast = m_sh[14]; m_pd = m_sh[13];
        m_bad = |m_sh[3:0];
      end
      h3 = h2; h2 = h1; h1 = {din, sclk, fs, cs_n};
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // every-clock comparison, covers R3 R4 R7 R9 timing
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk("R9 per-cycle outputs", {code, fast, pdown, bad, upd},
          {m_code, m_fast, m_pd, m_bad, m_upd});
      if (upd) upd_seen++;
    end
  end

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic shift_bits(input logic [15:0] w, input int nbits);
    for (int i = 0; i < nbits; i++) begin
      din = w[15-i]; wt(H);
      sclk = 1'b0; wt(H);
      sclk = 1'b1;
    end
  endtask

  task automatic frame(input logic [15:0] w, input int nbits);
    fs = 1'b0; wt(H);
    shift_bits(w, nbits);
    wt(H); fs = 1'b1; wt(3 * H);
  endtask

  task automatic expect_out(input string tag, input logic [15:0] w, input int ups_before, input int ups_exp);
    chk({tag, " code"}, code, w[11:4]);
    chk({tag, " fast"}, fast, w[14]);
    chk({tag, " pdown"}, pdown, w[13]);
    chk({tag, " pad"}, bad, |w[3:0]);
    chk({tag, " upd count"}, upd_seen - ups_before, ups_exp);
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1;
      $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    int u;
    logic [15:0] last;
    wt(3);
    chk("R1 reset", {code, fast, pdown, bad, upd}, 12'h0);
    rst_n = 1'b1; wt(4);
    chk("R1 after release", {code, fast, pdown, bad, upd}, 12'h0);
    cs_n = 1'b0; wt(4);

    // R3 R4: MSB-first, fast flag, code
    u = upd_seen; frame(16'h4AB0, 16); expect_out("R4 fast word", 16'h4AB0, u, 1);
    // R4: power-down flag, don't-care bits 15 and 12 set
    u = upd_seen; frame(16'hB5C0, 16); expect_out("R4 pdown word", 16'h2000 | 16'h05C0, u, 1);
    // R6: nonzero padding still loaded
    u = upd_seen; frame(16'h0FF3, 16); expect_out("R6 bad pad", 16'h0FF3, u, 1);
    u = upd_seen; frame(16'h0010, 16); expect_out("R6 clean pad", 16'h0010, u, 1);
    last = 16'h0010;
    // R5: early commit after 12 bits
    u = upd_seen; frame(16'h6A5F, 12); expect_out("R5 early 12", 16'h6A5F >> 4, u, 1);
    last = 16'h6A5F >> 4;
    // R5: early commit after 3 bits
    u = upd_seen; frame(16'hE000, 3); expect_out("R5 early 3", 16'h0007, u, 1);
    last = 16'h0007;
    // R5: frame marker rise with no bits loads nothing
    u = upd_seen; frame(16'hFFFF, 0); expect_out("R5 empty frame", last, u, 0);
    // R2: select high, full frame ignored
    cs_n = 1'b1; wt(4);
    u = upd_seen; frame(16'h7FF0, 16); expect_out("R2 deselected", last, u, 0);
    cs_n = 1'b0; wt(4);
    // R8: abort mid-word, then clocks ignored
    u = upd_seen;
    fs = 1'b0; wt(H);
    shift_bits(16'h5550, 9);
    wt(H); cs_n = 1'b1; wt(2 * H); cs_n = 1'b0; wt(2 * H);
    shift_bits(16'hFFFF, 7);
    wt(H); fs = 1'b1; wt(3 * H);
    expect_out("R8 abort", last, u, 0);
    // R3: restart after abort works, frame fall clears partial word
    u = upd_seen;
    fs = 1'b0; wt(H); shift_bits(16'hFFFF, 5); wt(H); fs = 1'b1; wt(2 * H);
    frame(16'h4120, 16);
    expect_out("R3 restart", 16'h4120, u, 2);
    // R7: zero word still pulses once
    u = upd_seen; frame(16'h0000, 16); expect_out("R7 zero word", 16'h0000, u, 1);
    wt(10);
    finish_run();
  end
endmodule